// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory can take normal traffic. First it holds clock-enable low and drives command inhibit. Partway through a long stabilization window it raises clock-enable and drives NOP. It then issues one precharge to all banks, a programmable number of auto-refresh commands and a load of the mode register. After each of these commands it drives a NOP gap sized from a time given in nanoseconds. The refresh loop can be placed before or after the mode load.

Every wait uses one shared down-counter. The length of each wait is computed at elaboration as max(1, ceil(t_ns × CLK_MHZ / 1000)) cycles. When the last wait ends the block raises `init_done` and hands the pins to a normal-operation controller. From then on the pins carry that controller's command inputs. Before that point the controller's inputs have no effect. The refresh count, the loop placement and the mode value are captured while clock-enable is low.

The sequencer has these states:
- ST_CKE_LOW: drives inhibit with clock-enable low. It moves to ST_STAB when the counter expires.
- ST_STAB: drives NOP. It moves to ST_PRE when the counter expires.
- ST_PRE: moves to ST_PRE_WAIT.
- ST_PRE_WAIT: moves to ST_REF, or to ST_LMR when refresh comes after the mode load.
- ST_REF: moves to ST_REF_WAIT.
- ST_REF_WAIT: moves back to ST_REF while refreshes remain. When none remain it moves to ST_LMR, or to ST_DONE when refresh comes after the mode load.
- ST_LMR: moves to ST_LMR_WAIT.
- ST_LMR_WAIT: moves to ST_DONE, or to ST_REF when refresh comes after the mode load.
- ST_DONE: final state, left only by reset.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after each release of reset until clock-enable rises, `sd_cke`=0 and the pins carry inhibit. Inhibit means {cs_n,ras_n,cas_n,we_n}=1111, `sd_ba`=0 and `sd_addr`=0. Also `init_done`=0. `sd_cke` first reads 1 after rising edge CKE_CYC+1 following the release of reset, where CKE_CYC is the cycle count of T_CKE_NS.
- R2: Once clock-enable is high it stays high. Only NOP (0111) is driven until the precharge-all command appears after edge STAB_CYC+1. Precharge-all is 0010 with `sd_addr`=0x400 (bit 10 high, all other bits 0) and `sd_ba`=0.
- R3: Each precharge, auto-refresh and mode load is one cycle long. It is followed by exactly N NOP cycles, where N = max(1, ceil(t_ns × CLK_MHZ / 1000)) for tRP, tRFC and tMRD respectively.
- R4: The number of auto-refresh commands (0001) is max(2, `cfg_ref_num`).
- R5: The mode load is 0000, with `sd_ba`=0 and `sd_addr` equal to the captured `cfg_mode`.
- R6: With `cfg_ref_after_mode`=0 the order is precharge, then the refreshes, then the mode load. With `cfg_ref_after_mode`=1 the order is precharge, then the mode load, then the refreshes.
- R7: `init_done` rises on the edge right after the last NOP of the final wait. It stays high until reset.
- R8: The host command inputs have no effect on the pins before `init_done`. While `init_done` is high, each pin equals the corresponding host input one cycle earlier, and `sd_cke`=1.
- R9: Reset asserted at any point returns the block to the R1 state on the next edge, and a fresh full sequence follows the release.
- R10: `cfg_ref_num`, `cfg_ref_after_mode` and `cfg_mode` are captured during reset and while clock-enable is low. Changes made after clock-enable rises have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ref_num | input | CNT_W | Requested auto-refresh count (values below 2 act as 2) |
| cfg_ref_after_mode | input | 1 | 1 places the refresh loop after the mode load |
| cfg_mode | input | ADDR_W | Mode value driven on the address bus during the mode load |
| host_cs_n | input | 1 | Controller chip select, passed through after init |
| host_ras_n | input | 1 | Controller row strobe, passed through after init |
| host_cas_n | input | 1 | Controller column strobe, passed through after init |
| host_we_n | input | 1 | Controller write enable, passed through after init |
| host_ba | input | BA_W | Controller bank address, passed through after init |
| host_addr | input | ADDR_W | Controller address, passed through after init |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address bus |
| init_done | output | 1 | High once the whole sequence has finished |

## Verification
The bench sweeps refresh counts 0 through 5 in both loop placements. It records the edge index of every command and of the clock-enable rise, and compares each against an expected timeline built from the cycle formulas. The sweep catches the following faults:
- An off-by-one in the shared counter would shift every later command by one cycle.
- Missing the clamp to two refreshes would issue zero or one refresh.
- Testing the placement flag at the wrong branch would swap or drop the mode load.

Separate runs cover three more cases:
- A reset asserted in the middle of the refresh loop, where a design that only partly restarts would keep clock-enable high or leave `init_done` set.
- Configuration changed after clock-enable rises, where a design without capture would follow the new count or placement.
- Host commands held non-idle during init and then pass-through after it, where a design that leaks or delays the host path would put foreign commands on the pins.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_CKE_LOW,
        ST_STAB,
        ST_PRE,
        ST_PRE_WAIT,
        ST_REF,
        ST_REF_WAIT,
        ST_LMR,
        ST_LMR_WAIT,
        ST_DONE
    } init_state_e;

    // Active-low {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_INHIBIT = 4'b1111;
    localparam logic [3:0] CMD_NOP     = 4'b0111;
    localparam logic [3:0] CMD_PRE     = 4'b0010;
    localparam logic [3:0] CMD_REF     = 4'b0001;
    localparam logic [3:0] CMD_LMR     = 4'b0000;

    // Cycles covering t_ns at mhz, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned mhz);
        int unsigned c;
        c = (t_ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int TW      = 13,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int ADDR_W   = 12,
    parameter int TW       = 13,
    parameter int CKE_CYC  = 2500,
    parameter int STAB_CYC = 5000,
    parameter int RP_CYC   = 1,
    parameter int RFC_CYC  = 4,
    parameter int MRD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_ref_num,
    input  logic              cfg_ref_after_mode,
    input  logic [ADDR_W-1:0] cfg_mode,
    input  logic              tm_expired,
    output init_state_e       state,
    output logic              tm_load,
    output logic [TW-1:0]     tm_val,
    output logic [ADDR_W-1:0] mode_val
);

    localparam logic [TW-1:0] LD_STAB = TW'(STAB_CYC - CKE_CYC - 1);
    localparam logic [TW-1:0] LD_RP   = TW'(RP_CYC - 1);
    localparam logic [TW-1:0] LD_RFC  = TW'(RFC_CYC - 1);
    localparam logic [TW-1:0] LD_MRD  = TW'(MRD_CYC - 1);

    init_state_e       state_q, state_d;
    logic [CNT_W-1:0]  tgt_q, ref_q;
    logic              after_q;
    logic [ADDR_W-1:0] mode_q;
    logic              refs_done;

    // Configuration capture while clock-enable is still low.
    always_ff @(posedge clk) begin
        if (rst || state_q == ST_CKE_LOW) begin
            tgt_q   <= (cfg_ref_num < CNT_W'(2)) ? CNT_W'(2) : cfg_ref_num;
            after_q <= cfg_ref_after_mode;
            mode_q  <= cfg_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q == ST_CKE_LOW) begin
            ref_q <= '0;
        end else if (state_q == ST_REF) begin
            ref_q <= ref_q + 1'b1;
        end
    end

    assign refs_done = (ref_q == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CKE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state_q)
            ST_CKE_LOW: begin
                if (tm_expired) begin
                    state_d = ST_STAB;
                    tm_load = 1'b1;
                    tm_val  = LD_STAB;
                end
            end
            ST_STAB: begin
                if (tm_expired) state_d = ST_PRE;
            end
            ST_PRE: begin
                state_d = ST_PRE_WAIT;
                tm_load = 1'b1;
                tm_val  = LD_RP;
            end
            ST_PRE_WAIT: begin
                if (tm_expired) state_d = after_q ? ST_LMR : ST_REF;
            end
            ST_REF: begin
                state_d = ST_REF_WAIT;
                tm_load = 1'b1;
                tm_val  = LD_RFC;
            end
            ST_REF_WAIT: begin
                if (tm_expired) begin
                    if (!refs_done)   state_d = ST_REF;
                    else if (after_q) state_d = ST_DONE;
                    else              state_d = ST_LMR;
                end
            end
            ST_LMR: begin
                state_d = ST_LMR_WAIT;
                tm_load = 1'b1;
                tm_val  = LD_MRD;
            end
            ST_LMR_WAIT: begin
                if (tm_expired) state_d = after_q ? ST_REF : ST_DONE;
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_CKE_LOW;
        endcase
    end

    assign state    = state_q;
    assign mode_val = mode_q;

endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_e       state,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic [3:0]        host_cmd,
    input  logic [BA_W-1:0]   host_ba,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              sd_cke,
    output logic [3:0]        sd_cmd,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    logic [3:0]        seq_cmd;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_cke;

    always_comb begin
        seq_cmd  = CMD_NOP;
        seq_addr = '0;
        seq_cke  = 1'b1;
        unique case (state)
            ST_CKE_LOW: begin
                seq_cmd = CMD_INHIBIT;
                seq_cke = 1'b0;
            end
            ST_PRE: begin
                seq_cmd      = CMD_PRE;
                seq_addr[10] = 1'b1;
            end
            ST_REF: seq_cmd = CMD_REF;
            ST_LMR: begin
                seq_cmd  = CMD_LMR;
                seq_addr = mode_val;
            end
            default: seq_cmd = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_cke    <= 1'b0;
            sd_cmd    <= CMD_INHIBIT;
            sd_ba     <= '0;
            sd_addr   <= '0;
            init_done <= 1'b0;
        end else if (state == ST_DONE) begin
            sd_cke    <= 1'b1;
            sd_cmd    <= host_cmd;
            sd_ba     <= host_ba;
            sd_addr   <= host_addr;
            init_done <= 1'b1;
        end else begin
            sd_cke    <= seq_cke;
            sd_cmd    <= seq_cmd;
            sd_ba     <= '0;
            sd_addr   <= seq_addr;
            init_done <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int T_PWR_NS  = 100000,
    parameter int T_CKE_NS  = 50000,
    parameter int T_RP_NS   = 20,
    parameter int T_RFC_NS  = 70,
    parameter int T_MRD_NS  = 30,
    parameter int CNT_W     = 4,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_ref_num,
    input  logic              cfg_ref_after_mode,
    input  logic [ADDR_W-1:0] cfg_mode,
    input  logic              host_cs_n,
    input  logic              host_ras_n,
    input  logic              host_cas_n,
    input  logic              host_we_n,
    input  logic [BA_W-1:0]   host_ba,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int CKE_CYC  = ns_to_cyc(T_CKE_NS, CLK_MHZ);
    localparam int STAB_RAW = ns_to_cyc(T_PWR_NS, CLK_MHZ);
    localparam int STAB_CYC = (STAB_RAW > CKE_CYC) ? STAB_RAW : CKE_CYC + 1;
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int RFC_CYC  = ns_to_cyc(T_RFC_NS, CLK_MHZ);
    localparam int MRD_CYC  = ns_to_cyc(T_MRD_NS, CLK_MHZ);
    localparam int TW       = $clog2(STAB_CYC + 1);

    init_state_e       state;
    logic              tm_load, tm_expired;
    logic [TW-1:0]     tm_val;
    logic [ADDR_W-1:0] mode_val;
    logic [3:0]        sd_cmd;

    sdram_init_timer #(
        .TW      (TW),
        .RST_VAL (CKE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_expired)
    );

    sdram_init_fsm #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .TW       (TW),
        .CKE_CYC  (CKE_CYC),
        .STAB_CYC (STAB_CYC),
        .RP_CYC   (RP_CYC),
        .RFC_CYC  (RFC_CYC),
        .MRD_CYC  (MRD_CYC)
    ) u_fsm (
        .clk                (clk),
        .rst                (rst),
        .cfg_ref_num        (cfg_ref_num),
        .cfg_ref_after_mode (cfg_ref_after_mode),
        .cfg_mode           (cfg_mode),
        .tm_expired         (tm_expired),
        .state              (state),
        .tm_load            (tm_load),
        .tm_val             (tm_val),
        .mode_val           (mode_val)
    );

    sdram_pin_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mode_val  (mode_val),
        .host_cmd  ({host_cs_n, host_ras_n, host_cas_n, host_we_n}),
        .host_ba   (host_ba),
        .host_addr (host_addr),
        .sd_cke    (sd_cke),
        .sd_cmd    (sd_cmd),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .init_done (init_done)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = sd_cmd;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              host_cs_n,
    input logic              host_ras_n,
    input logic              host_cas_n,
    input logic              host_we_n,
    input logic [BA_W-1:0]   host_ba,
    input logic [ADDR_W-1:0] host_addr,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    logic [3:0] cmd, hcmd;
    assign cmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign hcmd = {host_cs_n, host_ras_n, host_cas_n, host_we_n};

    AST_INHIBIT_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (cmd == 4'b1111)); // R1

    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke); // R2

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (!init_done && cmd == 4'b0010) |-> (sd_addr[10] && $past(sd_cke))); // R2

    AST_REF_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
        (!init_done && cmd == 4'b0001) |=> (cmd == 4'b0111)); // R3

    AST_LMR_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!init_done && cmd == 4'b0000) |-> (sd_ba == '0)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R7

    AST_HOST_PASS: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (sd_cke && cmd == $past(hcmd) && sd_ba == $past(host_ba)
                       && sd_addr == $past(host_addr))); // R8

    AST_RESET_RESTART: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sd_cke && !init_done)); // R9

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_cs_n  (host_cs_n),
    .host_ras_n (host_ras_n),
    .host_cas_n (host_cas_n),
    .host_we_n  (host_we_n),
    .host_ba    (host_ba),
    .host_addr  (host_addr),
    .sd_cke     (sd_cke),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_ba      (sd_ba),
    .sd_addr    (sd_addr),
    .init_done  (init_done)
);

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;

    localparam int MHZ = 50;
    localparam int AW  = 12;
    localparam int BW  = 2;
    localparam int CW  = 4;

    function automatic int cyc(input int t_ns);
        int c;
        c = (t_ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_CKE = 2500;  // 50 us
    localparam int E_STB = 5000;  // 100 us
    localparam int E_RP  = 1;     // 20 ns
    localparam int E_RFC = 4;     // 70 ns -> 3.5 rounded up
    localparam int E_MRD = 2;     // 30 ns -> 1.5 rounded up

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_ref_num = 4'd2;
    logic          cfg_after = 1'b0;
    logic [AW-1:0] cfg_mode = '0;
    logic          h_cs = 1'b0, h_ras = 1'b0, h_cas = 1'b1, h_we = 1'b1;
    logic [BW-1:0] h_ba = 2'd3;
    logic [AW-1:0] h_addr = 12'hFFF;
    logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [BW-1:0] sd_ba;
    logic [AW-1:0] sd_addr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ (MHZ), .T_PWR_NS (100000), .T_CKE_NS (50000),
        .T_RP_NS (20), .T_RFC_NS (70), .T_MRD_NS (30),
        .CNT_W (CW), .ADDR_W (AW), .BA_W (BW)
    ) u_dut (
        .clk (clk), .rst (rst),
        .cfg_ref_num (cfg_ref_num), .cfg_ref_after_mode (cfg_after),
        .cfg_mode (cfg_mode),
        .host_cs_n (h_cs), .host_ras_n (h_ras), .host_cas_n (h_cas),
        .host_we_n (h_we), .host_ba (h_ba), .host_addr (h_addr),
        .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
        .sd_addr (sd_addr), .init_done (init_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: act=%0d exp=<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pins_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic hold_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!sd_cke && pins_cmd() == 4'b1111 && sd_addr == '0 && sd_ba == '0
            && !init_done, "R1 reset state", {sd_cke, pins_cmd()}, 5'b01111);
        rst = 1'b0;
    endtask

    // Run one sequence from reset release; chg alters the configuration
    // after clock-enable rises (R10).
    task automatic run_seq(input int nref_cfg, input bit after,
                           input logic [AW-1:0] mode, input bit chg);
        int ev_t[16];
        logic [3:0] ev_c[16];
        logic [AW-1:0] ev_a[16];
        logic [BW-1:0] ev_b[16];
        int n = 0;
        int cke_t = -1;
        int done_t = -1;
        int leak = 0;
        int host_seen = 0;
        int nref;
        int exp_n;
        int t;
        logic [3:0] exp_c[16];
        int exp_t[16];
        cfg_ref_num = CW'(nref_cfg);
        cfg_after   = after;
        cfg_mode    = mode;
        h_cs = 1'b0; h_ras = 1'b0; h_cas = 1'b1; h_we = 1'b1;
        h_ba = 2'd3; h_addr = 12'hFFF;
        hold_reset();
        for (int k = 1; k <= 6000; k++) begin
            @(negedge clk);
            if (chg && k == E_CKE + 5) begin
                cfg_ref_num = 4'd5;
                cfg_after   = ~after;
                cfg_mode    = ~mode;
            end
            if (cke_t < 0 && sd_cke) cke_t = k;
            if (init_done) begin
                done_t = k;
                break;
            end
            if (!sd_cke && pins_cmd() != 4'b1111) leak++;
            if (sd_cke && pins_cmd() == 4'b1111) leak++;
            if (pins_cmd() == 4'b0011) host_seen++;
            if (pins_cmd() != 4'b0111 && pins_cmd() != 4'b1111 && n < 16) begin
                ev_t[n] = k; ev_c[n] = pins_cmd(); ev_a[n] = sd_addr; ev_b[n] = sd_ba;
                n++;
            end
        end
        // Expected timeline
        nref  = (nref_cfg < 2) ? 2 : nref_cfg;
        exp_n = nref + 2;
        t = E_STB + 1;
        exp_c[0] = 4'b0010; exp_t[0] = t; t = t + E_RP + 1;
        for (int i = 1; i < exp_n; i++) begin
            bit is_lmr;
            is_lmr = after ? (i == 1) : (i == exp_n - 1);
            exp_c[i] = is_lmr ? 4'b0000 : 4'b0001;
            exp_t[i] = t;
            t = t + (is_lmr ? E_MRD : E_RFC) + 1;
        end
        chk(cke_t == E_CKE + 1, "R1 cke rise edge", cke_t, E_CKE + 1);
        chk(leak == 0, "R2 only inhibit/NOP before commands", leak, 0);
        chk(host_seen == 0, "R8 host ignored during init", host_seen, 0);
        chk(n == exp_n, "R4 command count", n, exp_n);
        for (int i = 0; i < exp_n && i < n; i++) begin
            chk(ev_c[i] == exp_c[i], "R6 command order", ev_c[i], exp_c[i]);
            chk(ev_t[i] == exp_t[i], "R3 command edge", ev_t[i], exp_t[i]);
            if (exp_c[i] == 4'b0010)
                chk(ev_a[i] == 12'h400 && ev_b[i] == '0, "R2 precharge all", ev_a[i], 12'h400);
            if (exp_c[i] == 4'b0000)
                chk(ev_a[i] == mode && ev_b[i] == '0, "R5 mode load value", ev_a[i], mode);
        end
        chk(done_t == t, "R7 init_done edge", done_t, t);
    endtask

    initial begin
        // Sweep refresh counts and both placements
        for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 6; r++) begin
                run_seq(r, a[0], AW'(12'h020 + r * 17 + a * 256), 1'b0);
            end
        end

        // R10: configuration change after clock-enable rises is ignored
        run_seq(3, 1'b0, 12'h033, 1'b1);
        run_seq(4, 1'b1, 12'h231, 1'b1);

        // R8: pass-through after init_done
        @(negedge clk);
        h_cs = 1'b0; h_ras = 1'b1; h_cas = 1'b0; h_we = 1'b0;
        h_ba = 2'd2; h_addr = 12'h155;
        @(negedge clk);
        chk(pins_cmd() == 4'b0100 && sd_ba == 2'd2 && sd_addr == 12'h155 && sd_cke,
            "R8 host pass write", pins_cmd(), 4'b0100);
        h_cs = 1'b0; h_ras = 1'b0; h_cas = 1'b1; h_we = 1'b1;
        h_ba = 2'd1; h_addr = 12'hAAA;
        @(negedge clk);
        chk(pins_cmd() == 4'b0011 && sd_ba == 2'd1 && sd_addr == 12'hAAA,
            "R8 host pass active", pins_cmd(), 4'b0011);
        chk(init_done == 1'b1, "R7 done held", init_done, 1);

        // R9: reset after done
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk(!init_done && !sd_cke && pins_cmd() == 4'b1111, "R9 reset after done",
            {init_done, sd_cke}, 0);
        rst = 1'b0;

        // R9: reset in the middle of the refresh loop
        cfg_ref_num = 4'd3; cfg_after = 1'b0; cfg_mode = 12'h0A5;
        for (int k = 1; k <= E_STB + 4; k++) @(negedge clk);
        chk(sd_cke == 1'b1, "R9 mid-sequence cke high", sd_cke, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!sd_cke && pins_cmd() == 4'b1111 && !init_done, "R9 mid-sequence reset",
            {sd_cke, pins_cmd()}, 5'b01111);
        run_seq(3, 1'b0, 12'h0A5, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule